// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block performs interrupt entry for a small 8-bit microcontroller core. It holds a vector of pending interrupt sources and a latched reset request. When the core's global interrupt enable is set and something is pending, it picks one winner and takes the current word program counter and the stack pointer. It then writes the return address to data memory one byte per clock, through a byte-wide write port, decrementing the stack pointer after each byte. Last, it presents the vector address and the updated stack pointer together with a one-cycle load strobe. In that same cycle it asks the core to clear its global enable.

A reset request outranks every hardware source and always vectors to word address 0. Hardware source i vectors to slot i+1. Parameters set the slot stride (1 or 2 words) and the return-address width (1, 2 or 3 bytes). Only the serviced source bit is retired. Sources that fire while a sequence is running are collected and are not lost.

Top module: `irq_entry_seq`

## Requirements
- R1: After a synchronous reset (active high), `busy`, `mem_we`, `done`, `gie_clr`, `pending`, `hw_req` and `rst_pending` are all 0.
- R2: While `glob_ie` is 0, no sequence starts. `busy` stays 0, no memory write occurs, and pending state is kept.
- R3: A latched reset request is serviced ahead of any pending hardware bit. It vectors to `pc_new` = 0 and leaves `pending` unchanged.
- R4: With no reset request, the least significant set bit i of the registered `pending` wins, and `pc_new` = (i+1) × SLOT_WORDS.
- R5: Entry is accepted on the clock edge where the block is idle with `glob_ie`=1 and a request pending. On the next PC_BYTES cycles, `mem_we`=1 with one byte per cycle. Byte k (k=0 is the least significant byte of the sampled `pc_in`) goes to address `sp_in` − k.
- R6: In the `done` cycle, `sp_out` equals the sampled `sp_in` − PC_BYTES (modulo 2^SP_W).
- R7: `done` and `gie_clr` are a single-cycle pulse in the cycle after the last push. `busy` is 1 from the cycle after acceptance through the `done` cycle, and 0 in the cycle after it.
- R8: A hardware entry clears only the serviced bit. `hw_req` stays 1 while any other bit remains set.
- R9: Bits pulsed on `pend_set` during a sequence are ORed into `pending` and are still set after `done`.
- R10: Asserting `rst` in the middle of a sequence returns the block to idle with no further memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_ie | input | 1 | Core global interrupt enable flag |
| rst_req | input | 1 | Pulse that latches a reset request |
| pend_set | input | NUM_SRC | Pulses that set pending source bits |
| pc_in | input | 8×PC_BYTES | Current word program counter (return address) |
| sp_in | input | SP_W | Current stack pointer |
| busy | output | 1 | Entry sequence in progress |
| mem_we | output | 1 | Data-memory byte write strobe |
| mem_addr | output | SP_W | Data-memory write address |
| mem_wdata | output | 8 | Data-memory write byte |
| done | output | 1 | Load strobe for `pc_new` and `sp_out` |
| pc_new | output | 8×PC_BYTES | Vector word address |
| sp_out | output | SP_W | Stack pointer after the pushes |
| gie_clr | output | 1 | Request to clear the global enable |
| pending | output | NUM_SRC | Registered pending source bits |
| hw_req | output | 1 | Any hardware source pending |
| rst_pending | output | 1 | Reset request latched |

## Verification
Random masks with several bits set check that the lowest bit wins and that only that bit clears. Single-bit masks at the top and bottom index check the vector arithmetic at both ends. A reset request mixed with hardware bits checks that reset comes first and that the hardware bits are left alone. Entries with the enable low check that nothing starts, bits injected during the pushes check that they are kept, and a reset in mid-push checks that the sequence is abandoned.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int NUM_SRC    = 8,
  parameter int PC_BYTES   = 2,
  parameter int SLOT_WORDS = 2,
  parameter int SP_W       = 16,
  localparam int PC_W      = 8 * PC_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glob_ie,
  input  logic               rst_req,
  input  logic [NUM_SRC-1:0] pend_set,
  input  logic [PC_W-1:0]    pc_in,
  input  logic [SP_W-1:0]    sp_in,
  output logic               busy,
  output logic               mem_we,
  output logic [SP_W-1:0]    mem_addr,
  output logic [7:0]         mem_wdata,
  output logic               done,
  output logic [PC_W-1:0]    pc_new,
  output logic [SP_W-1:0]    sp_out,
  output logic               gie_clr,
  output logic [NUM_SRC-1:0] pending,
  output logic               hw_req,
  output logic               rst_pending
);
  localparam int IW  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int SLW = $clog2(NUM_SRC + 1);

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_LOAD} st_t;

  st_t               st;
  logic [NUM_SRC-1:0] pend_q, low_bit;
  logic              rst_q, start;
  logic [IW-1:0]     win_idx;
  logic [SLW-1:0]    slot_q;
  logic [PC_W-1:0]   ret_q;
  logic [SP_W-1:0]   sp_q;
  logic [1:0]        cnt;

  always_comb begin
    win_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pend_q[i]) win_idx = IW'(i);
  end

  assign low_bit = pend_q & (~pend_q + 1'b1);
  assign start   = (st == S_IDLE) && glob_ie && (rst_q || (|pend_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      pend_q <= '0;
      rst_q  <= 1'b0;
      slot_q <= '0;
      ret_q  <= '0;
      sp_q   <= '0;
      cnt    <= '0;
    end else begin
      pend_q <= (pend_q | pend_set) & ~((start && !rst_q) ? low_bit : '0);
      rst_q  <= (rst_q & ~start) | rst_req;
      case (st)
        S_IDLE: if (start) begin
          slot_q <= rst_q ? '0 : SLW'(win_idx) + 1'b1;
          ret_q  <= pc_in;
          sp_q   <= sp_in;
          cnt    <= '0;
          st     <= S_PUSH;
        end
        S_PUSH: begin
          sp_q <= sp_q - 1'b1;
          cnt  <= cnt + 1'b1;
          if (cnt == 2'(PC_BYTES - 1)) st <= S_LOAD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign mem_we      = (st == S_PUSH);
  assign mem_addr    = sp_q;
  assign mem_wdata   = 8'(ret_q >> {cnt, 3'b000});
  assign done        = (st == S_LOAD);
  assign gie_clr     = done;
  assign pc_new      = PC_W'(slot_q) * PC_W'(SLOT_WORDS);
  assign sp_out      = sp_q;
  assign pending     = pend_q;
  assign hw_req      = |pend_q;
  assign rst_pending = rst_q;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int NUM_SRC = 8,
  parameter int SP_W    = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               glob_ie,
  input logic               busy,
  input logic               mem_we,
  input logic [SP_W-1:0]    mem_addr,
  input logic               done,
  input logic               gie_clr,
  input logic [NUM_SRC-1:0] pending
);
  p_no_write_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_we);
  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 1'b1));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);
  p_done_after_push_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(mem_we) && gie_clr));
  p_hold_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !glob_ie) |=> !busy);
  p_keep_bits_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> ((pending & $past(pending)) == $past(pending)));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.NUM_SRC(NUM_SRC), .SP_W(SP_W)) u_chk (
  .clk(clk), .rst(rst), .glob_ie(glob_ie), .busy(busy), .mem_we(mem_we),
  .mem_addr(mem_addr), .done(done), .gie_clr(gie_clr), .pending(pending)
);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
  localparam int NS = 8, PB = 2, SW = 2, SPW = 16, PCW = 8 * PB;

  logic clk = 0, rst = 1, glob_ie = 0, rst_req = 0;
  logic [NS-1:0] pend_set = '0;
  logic [PCW-1:0] pc_in = '0;
  logic [SPW-1:0] sp_in = '0;
  logic busy, mem_we, done, gie_clr, hw_req, rst_pending;
  logic [SPW-1:0] mem_addr, sp_out;
  logic [7:0] mem_wdata;
  logic [PCW-1:0] pc_new;
  logic [NS-1:0] pending;

  int total = 0, bad = 0;
  logic [NS-1:0] em = '0;
  logic er = 0;

  always #2.5 clk = ~clk;

  irq_entry_seq #(.NUM_SRC(NS), .PC_BYTES(PB), .SLOT_WORDS(SW), .SP_W(SPW)) u_irq_entry_seq (
    .clk(clk), .rst(rst), .glob_ie(glob_ie), .rst_req(rst_req), .pend_set(pend_set),
    .pc_in(pc_in), .sp_in(sp_in), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .done(done), .pc_new(pc_new), .sp_out(sp_out),
    .gie_clr(gie_clr), .pending(pending), .hw_req(hw_req), .rst_pending(rst_pending));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int low_idx(input logic [NS-1:0] m);
    for (int i = 0; i < NS; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic inject(input logic [NS-1:0] m, input bit r);
    pend_set = m; rst_req = r;
    tick();
    pend_set = '0; rst_req = 0;
    em |= m; er |= r;
  endtask

  task automatic service(input logic [PCW-1:0] pc, input logic [SPW-1:0] sp, input logic [NS-1:0] late);
    logic [PCW-1:0] epc;
    logic [NS-1:0] bit_m;
    if (er) begin
      epc = '0; er = 0;
    end else begin
      epc = PCW'((low_idx(em) + 1) * SW);
      bit_m = em & (~em + 1'b1);
      em &= ~bit_m;
    end
    pc_in = pc; sp_in = sp; glob_ie = 1;
    tick();
    glob_ie = 0;
    for (int b = 0; b < PB; b++) begin
      chk(mem_we && busy, "R5 we", {30'b0, busy, mem_we}, 3);
      chk(mem_addr == sp - SPW'(b), "R5 addr", mem_addr, sp - SPW'(b));
      chk(mem_wdata == 8'(pc >> (8 * b)), "R5 data", mem_wdata, 8'(pc >> (8 * b)));
      if (b == 0) begin pend_set = late; em |= late; end
      tick();
      pend_set = '0;
    end
    chk(done && gie_clr && !mem_we && busy, "R7 done", {done, gie_clr, mem_we, busy}, 4'b1101);
    chk(pc_new == epc, "R4/R3 vector", pc_new, epc);
    chk(sp_out == sp - SPW'(PB), "R6 sp", sp_out, sp - SPW'(PB));
    chk(pending == em, "R8/R9 pending", pending, em);
    chk(hw_req == (em != 0), "R8 hw_req", hw_req, em != 0);
    tick();
    chk(!done && !busy && !gie_clr, "R7 pulse", {done, busy, gie_clr}, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    tick(); tick();
    rst = 0;
    chk({busy, mem_we, done, gie_clr, hw_req, rst_pending} == 0 && pending == 0, "R1 reset",
        {busy, mem_we, done, gie_clr, hw_req, rst_pending}, 0);

    inject(8'b1010_0100, 0);
    glob_ie = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(!busy && !mem_we, "R2 held", {busy, mem_we}, 0);
    end
    chk(pending == em, "R2 kept", pending, em);

    inject(8'b0000_0001, 1);
    chk(rst_pending, "R3 latched", rst_pending, 1);
    service(16'hBEEF, 16'h08FF, '0);
    service(16'h1234, 16'h0100, '0);
    chk(pending == 8'b1010_0100, "R8 one cleared", pending, 8'b1010_0100);
    service(16'h00A5, 16'h0002, 8'b0000_0010);
    inject(8'b1000_0000, 0);
    while (em != 0) service(16'hFFFF, 16'h0001, '0);

    inject(8'b0000_0110, 0);
    pc_in = 16'h4242; sp_in = 16'h0300; glob_ie = 1;
    tick(); glob_ie = 0;
    tick();
    rst = 1; tick(); rst = 0; em = '0; er = 0;
    chk(!busy && !mem_we && pending == 0, "R10 abort", {busy, mem_we, pending}, 0);
    tick();
    chk(!mem_we && !done, "R10 idle", {mem_we, done}, 0);

    for (int it = 0; it < 60; it++) begin
      logic [NS-1:0] m = NS'($urandom);
      bit r = ($urandom % 5) == 0;
      inject(m, r);
      if (em == 0 && !er) begin
        glob_ie = 1; tick(); glob_ie = 0;
        chk(!busy, "R2 nothing pending", busy, 0);
      end else begin
        service(PCW'($urandom), SPW'($urandom), ($urandom % 4 == 0) ? NS'($urandom) : '0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule